// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns a software-selected operating mode into clock enables and gated clocks for a small microcontroller. There are six modes: one active mode and five sleep levels. Each sleep level switches off a different set of resources: the CPU clock, the peripheral clock, the auxiliary clock, the DC bias of the digitally controlled oscillator, and the crystal oscillator. The analog oscillators are outside the block. It drives logical enables for them and gates one reference clock into three synchronously gated clock outputs.

When an interrupt request arrives, the block saves the current mode in a one-entry register and forces the active mode, so the service routine can run. The oscillator enables rise combinationally from the request line, so a request is honoured even in the deepest sleep level, where no gated clock runs. A return-from-interrupt strobe puts the saved mode back. Each gated clock uses a latch that is transparent only while the reference clock is low, so an enable change never cuts a high pulse short.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (active), isr_o is 0 and all six enables are 1.
- R2: With mode_wr_i high at a clock edge and mode_i in 0..5, mode_o takes mode_i after that edge. The codes are 0 = active and 1..5 = sleep levels 0..4.
- R3: A write of code 6 or 7 is ignored, and mode_o keeps its value.
- R4: Mode 0 enables everything. Mode 1 turns off cpu_en_o and mclk_en_o and keeps the peripheral clock, the auxiliary clock, the DC generator and the crystal enabled.
- R5: Mode 2 matches mode 1 except that dcgen_en_o equals dco_used_i.
- R6: Mode 3 turns off the CPU, the main clock and the peripheral clock, and keeps the auxiliary clock and the DC generator on. Mode 4 is the same with the DC generator off. The crystal stays on in both.
- R7: In mode 5 with no request pending, all six enables are 0.
- R8: A clock edge with irq_i high and isr_o low saves mode_o, sets mode_o to 0 and sets isr_o to 1.
- R9: While irq_i is high, dcgen_en_o and xtal_en_o are 1 in the same cycle, in any mode.
- R10: reti_i at an edge with isr_o high restores the saved mode and clears isr_o. With isr_o low it has no effect.
- R11: irq_i held high while isr_o is 1 does not overwrite the saved mode.
- R12: Each gated clock equals clk_i while its enable is high. It stays low otherwise. An enable change reaches the gated clock from the first high phase after the edge that changed the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code to write |
| dco_used_i | input | 1 | DCO feeds the active-mode clock |
| irq_i | input | 1 | Interrupt request level |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mode_o | output | 3 | Current mode |
| isr_o | output | 1 | Interrupt service in progress |
| cpu_en_o | output | 1 | CPU run enable |
| mclk_en_o | output | 1 | Main clock enable |
| smclk_en_o | output | 1 | Peripheral clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| dcgen_en_o | output | 1 | DCO DC generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| mclk_o | output | 1 | Gated main clock |
| smclk_o | output | 1 | Gated peripheral clock |
| aclk_o | output | 1 | Gated auxiliary clock |

## Verification
The assertions assume that irq_i, reti_i, mode_wr_i and mode_i change only away from the rising edge of clk_i. They also assume that clk_i keeps toggling in every mode, so the mode register can still move out of the deepest sleep level. The bench changes all inputs a quarter period after a rising edge and never stops the clock. It lowers irq_i before it pulses reti_i, so that a held request does not re-enter service at once.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;
  localparam int NUM_MODES = 6;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACT  = 3'd0,
    MODE_SL0  = 3'd1,
    MODE_SL1  = 3'd2,
    MODE_SL2  = 3'd3,
    MODE_SL3  = 3'd4,
    MODE_SL4  = 3'd5
  } lpm_mode_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic dcgen;
    logic xtal;
  } clk_en_t;

  function automatic logic mode_ok(logic [MODE_W-1:0] m);
    return int'(m) < NUM_MODES;
  endfunction
endpackage

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_i,
  input  logic              reti_i,
  output lpm_mode_e         mode_o,
  output lpm_mode_e         saved_o,
  output logic              isr_o
);
  lpm_mode_e mode_q, saved_q;
  logic      isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_ACT;
      saved_q <= MODE_ACT;
      isr_q   <= 1'b0;
    end else if (irq_i && !isr_q) begin
      saved_q <= mode_q;
      mode_q  <= MODE_ACT;
      isr_q   <= 1'b1;
    end else if (reti_i && isr_q) begin
      mode_q  <= saved_q;
      isr_q   <= 1'b0;
    end else if (mode_wr_i && mode_ok(mode_i)) begin
      mode_q  <= lpm_mode_e'(mode_i);
    end
  end

  assign mode_o  = mode_q;
  assign saved_o = saved_q;
  assign isr_o   = isr_q;
endmodule

// File: rtl/lpm_en_decode.sv
module lpm_en_decode
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_i,
  input  logic      dco_used_i,
  input  logic      irq_i,
  output clk_en_t   en_o
);
  clk_en_t base;

  always_comb begin
    base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, aclk: 1'b0, dcgen: 1'b0, xtal: 1'b0};
    unique case (mode_i)
      MODE_ACT: base = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1, aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};
      MODE_SL0: base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b1, aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};
      MODE_SL1: base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b1, aclk: 1'b1, dcgen: dco_used_i, xtal: 1'b1};
      MODE_SL2: base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};
      MODE_SL3: base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, aclk: 1'b1, dcgen: 1'b0, xtal: 1'b1};
      default:  base = '{cpu: 1'b0, mclk: 1'b0, smclk: 1'b0, aclk: 1'b0, dcgen: 1'b0, xtal: 1'b0};
    endcase
    en_o = base;
    // wake path: oscillators restart from the request line itself
    en_o.dcgen = base.dcgen | irq_i;
    en_o.xtal  = base.xtal  | irq_i;
  end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_GCLK = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dco_used_i,
  input  logic              irq_i,
  input  logic              reti_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              isr_o,
  output logic              cpu_en_o,
  output logic              mclk_en_o,
  output logic              smclk_en_o,
  output logic              aclk_en_o,
  output logic              dcgen_en_o,
  output logic              xtal_en_o,
  output logic              mclk_o,
  output logic              smclk_o,
  output logic              aclk_o
);
  lpm_mode_e             cur_mode, saved_mode;
  clk_en_t               en;
  logic [NUM_GCLK-1:0]   gate_en, gate_clk;

  lpm_mode_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (mode_wr_i),
    .mode_i    (mode_i),
    .irq_i     (irq_i),
    .reti_i    (reti_i),
    .mode_o    (cur_mode),
    .saved_o   (saved_mode),
    .isr_o     (isr_o)
  );

  lpm_en_decode u_dec (
    .mode_i     (cur_mode),
    .dco_used_i (dco_used_i),
    .irq_i      (irq_i),
    .en_o       (en)
  );

  assign gate_en = {en.aclk, en.smclk, en.mclk};

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gate
    lpm_clk_gate u_gate (
      .clk_i  (clk_i),
      .en_i   (gate_en[g]),
      .gclk_o (gate_clk[g])
    );
  end

  assign mode_o     = cur_mode;
  assign cpu_en_o   = en.cpu;
  assign mclk_en_o  = en.mclk;
  assign smclk_en_o = en.smclk;
  assign aclk_en_o  = en.aclk;
  assign dcgen_en_o = en.dcgen;
  assign xtal_en_o  = en.xtal;
  assign mclk_o     = gate_clk[0];
  assign smclk_o    = gate_clk[1];
  assign aclk_o     = gate_clk[2];
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic [2:0] mode_i,
  input logic       irq_i,
  input logic       reti_i,
  input logic [2:0] mode_o,
  input logic [2:0] saved_mode_i,
  input logic       isr_o,
  input logic       cpu_en_o,
  input logic       mclk_en_o,
  input logic       smclk_en_o,
  input logic       aclk_en_o,
  input logic       dcgen_en_o,
  input logic       xtal_en_o
);
  p_bad_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && mode_i > 3'd5 && !irq_i && !(reti_i && isr_o)) |=> mode_o == $past(mode_o));

  p_cpu_off_asleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd0) |-> (!cpu_en_o && !mclk_en_o));

  p_deep_all_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && !irq_i) |-> !(cpu_en_o || mclk_en_o || smclk_en_o || aclk_en_o || dcgen_en_o || xtal_en_o));

  p_irq_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !isr_o) |=> (mode_o == 3'd0 && isr_o && saved_mode_i == $past(mode_o)));

  p_wake_osc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (dcgen_en_o && xtal_en_o));

  p_reti_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o && reti_i && !mode_wr_i) |=> (!isr_o && mode_o == $past(saved_mode_i)));

  p_save_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o && irq_i) |=> saved_mode_i == $past(saved_mode_i));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_wr_i    (mode_wr_i),
  .mode_i       (mode_i),
  .irq_i        (irq_i),
  .reti_i       (reti_i),
  .mode_o       (mode_o),
  .saved_mode_i (saved_mode),
  .isr_o        (isr_o),
  .cpu_en_o     (cpu_en_o),
  .mclk_en_o    (mclk_en_o),
  .smclk_en_o   (smclk_en_o),
  .aclk_en_o    (aclk_en_o),
  .dcgen_en_o   (dcgen_en_o),
  .xtal_en_o    (xtal_en_o)
);

// File: tb/lpm_clk_ctrl_bench.sv
module lpm_clk_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       dco_used_i = 1'b1;
  logic       irq_i = 1'b0;
  logic       reti_i = 1'b0;
  logic [2:0] mode_o;
  logic       isr_o, cpu_en_o, mclk_en_o, smclk_en_o, aclk_en_o, dcgen_en_o, xtal_en_o;
  logic       mclk_o, smclk_o, aclk_o;

  int total = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  lpm_clk_ctrl u_lpm_clk_ctrl (.*);

  // order {cpu, mclk, smclk, aclk, dcgen, xtal}
  function automatic logic [5:0] exp_en(int m, logic dco);
    case (m)
      0: return 6'b111111;
      1: return 6'b001111;
      2: return {4'b0011, dco, 1'b1};
      3: return 6'b000111;
      4: return 6'b000101;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] got_en();
    return {cpu_en_o, mclk_en_o, smclk_en_o, aclk_en_o, dcgen_en_o, xtal_en_o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // to 5 ns after the next rising edge
  task automatic step();
    @(posedge clk_i);
    #5;
  endtask

  task automatic write_mode(int m);
    mode_wr_i = 1'b1;
    mode_i = 3'(m);
    step();
    mode_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 isr", 32'(isr_o), 0);
    chk("R1 enables", 32'(got_en()), 32'h3f);
  endtask

  task automatic t_modes();
    for (int m = 5; m >= 0; m--) begin
      write_mode(m);
      chk("R2 mode write", 32'(mode_o), 32'(m));
      chk("R4 R5 R6 R7 enables", 32'(got_en()), 32'(exp_en(m, dco_used_i)));
    end
  endtask

  task automatic t_dco_bias();
    write_mode(2);
    dco_used_i = 1'b0;
    #1 chk("R5 dcgen off when DCO unused", 32'(dcgen_en_o), 0);
    dco_used_i = 1'b1;
    #1 chk("R5 dcgen on when DCO used", 32'(dcgen_en_o), 1);
    step();
  endtask

  task automatic t_invalid();
    write_mode(3);
    write_mode(6);
    chk("R3 code 6 ignored", 32'(mode_o), 3);
    write_mode(7);
    chk("R3 code 7 ignored", 32'(mode_o), 3);
    chk("R3 enables kept", 32'(got_en()), 32'(exp_en(3, 1'b1)));
  endtask

  task automatic t_wake_deep();
    write_mode(5);
    chk("R7 all off", 32'(got_en()), 0);
    irq_i = 1'b1;
    #1 chk("R9 osc wake comb", 32'({dcgen_en_o, xtal_en_o}), 3);
    step();
    irq_i = 1'b0;
    chk("R8 mode active", 32'(mode_o), 0);
    chk("R8 isr set", 32'(isr_o), 1);
    chk("R8 cpu on", 32'({cpu_en_o, mclk_en_o}), 3);
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
    chk("R10 restored", 32'(mode_o), 5);
    chk("R10 isr cleared", 32'(isr_o), 0);
  endtask

  task automatic t_reti_idle();
    write_mode(2);
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
    chk("R10 reti outside ISR ignored", 32'(mode_o), 2);
    chk("R10 isr stays low", 32'(isr_o), 0);
  endtask

  task automatic t_nested();
    write_mode(4);
    irq_i = 1'b1;
    step();
    chk("R8 entry from mode 4", 32'(mode_o), 0);
    step();
    step();
    chk("R11 still in ISR", 32'(isr_o), 1);
    irq_i = 1'b0;
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
    chk("R11 saved mode kept", 32'(mode_o), 4);
  endtask

  task automatic t_gating();
    write_mode(0);
    step();
    chk("R12 mclk follows clk", 32'({aclk_o, smclk_o, mclk_o}), 32'h7);
    #10 chk("R12 low phase", 32'({aclk_o, smclk_o, mclk_o}), 0);
    #10;
    write_mode(3);
    chk("R12 old enable holds this phase", 32'(mclk_o), 1);
    step();
    chk("R12 mode 3 gating", 32'({aclk_o, smclk_o, mclk_o}), 32'h4);
    write_mode(5);
    step();
    chk("R12 mode 5 gating", 32'({aclk_o, smclk_o, mclk_o}), 0);
    write_mode(1);
    step();
    chk("R12 mode 1 gating", 32'({aclk_o, smclk_o, mclk_o}), 32'h6);
  endtask

  initial begin
    fork
      begin
        #35 rst_ni = 1'b1;
        @(posedge clk_i);
        #5;
        t_reset();
        t_modes();
        t_dco_bias();
        t_invalid();
        t_wake_deep();
        t_reti_idle();
        t_nested();
        t_gating();
      end
      begin
        repeat (100000) @(posedge clk_i);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule